// File: doc/BRIEF.md
# Scheduled Pulse Trigger Bank

This block holds eight independent trigger units that watch a running time-of-day value, given as seconds and nanoseconds, and drive general-purpose output pins at absolute instants. Each unit can produce a single pulse, a level that rises and stays up, or a periodic square wave whose high and low phases have separately programmed lengths. Every edge is scheduled against absolute time. After an edge, the next edge instant is found by adding the relevant width to the current one, carrying nanoseconds into seconds.

Software first writes a configuration word that picks the unit, its output pin and its mode. It then issues a load command and pushes the start time and the widths through a 16-bit data port, one word per strobe. An arm command starts the unit, and a stop command halts it and releases the pin. An optional late-start setting makes a unit fire at once when its start time has already passed at arming. Without that setting, such a unit never fires.

Top module: `ptrig_bank`

## Requirements
- R1: While reset is asserted, and after it is released, every pin of `gpio_o` is low and no unit is armed. Reset assertion clears the outputs at once, without waiting for a clock.
- R2: A strobe on `cfg_wr_i` stores the configuration word into the unit named by bits [2:0]. The remaining fields are: output pin number in bits [6:3] (1..12 selects `gpio_o[n-1]`, 0 selects none), periodic flag in bit 7, pulse flag in bit 8, and late-start flag in bit 9.
- R3: Command code 1 on `cmd_op_i` starts a load for unit `cmd_id_i`. The following `tdr_wr_i` strobes carry, in this order: start ns low half, start ns high half, start seconds low half, start seconds high half, first width low half, first width high half. Units 0 and 1 take two more words for a second width. Other units finish after six words and use the first width as their second width.
- R4: Command code 3 disarms the named unit, and its output is low after the same clock edge.
- R5: Command code 2 arms the named unit. Its output rises at the first clock edge at which the sampled time is at or after the start time. If the start time lies strictly before the time sampled at arming and late-start is clear, the unit disarms and never fires.
- R6: With late-start set, a unit armed after its start time rises at the next clock edge. Its schedule is then taken from the time sampled at arming.
- R7: With the periodic flag set, the output stays high for the first width and low for the second width, repeating until disarmed.
- R8: With pulse set and periodic clear, the unit emits one pulse of the first width and disarms. With both flags clear, the output rises at the start time and stays high until disarmed.
- R9: Each next edge time is the current edge time plus the width, and a nanosecond sum of 1,000,000,000 or more wraps into the next second. Widths are below one second.
- R10: When several units select the same pin, the lowest-numbered one drives it, even while its output is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| now_sec_i | input | 32 | Current time, seconds |
| now_ns_i | input | 32 | Current time, nanoseconds within the second |
| cfg_wr_i | input | 1 | Configuration write strobe |
| cfg_word_i | input | 10 | Configuration word (unit, pin, periodic, pulse, late-start) |
| cmd_op_i | input | 2 | Command: 0 none, 1 load, 2 arm, 3 disarm |
| cmd_id_i | input | 3 | Unit addressed by the command |
| tdr_wr_i | input | 1 | Time data word strobe |
| tdr_data_i | input | 16 | Time data word |
| gpio_o | output | 12 | Output pins |

## Verification
The bench places a periodic edge just below a second boundary. A design that dropped the carry would schedule the fall almost a second early, and the low phase would come too soon or never. It checks the one-cycle boundary just before and at each edge instant, which catches an off-by-one compare, and it loads the second width on unit 0 with a value different from the first, so a loader that counted words wrongly for the wide units would never commit or would mix up the phases. It also arms two units with already-passed start times: one with late-start, which must pulse at once for exactly its width, and one without, which must stay quiet. Finally it puts two units on one pin, so that a reversed priority shows the busy higher-numbered unit instead of the idle lower one.

// File: rtl/ptrig_pkg.sv
`timescale 1ns/1ps
package ptrig_pkg;

  localparam int unsigned SEC_W      = 32;
  localparam int unsigned NS_W       = 32;
  localparam int unsigned PIN_W      = 4;
  localparam int unsigned WORD_W     = 16;
  localparam int unsigned NS_PER_SEC = 1_000_000_000;

  typedef struct packed {
    logic [SEC_W-1:0] sec;
    logic [NS_W-1:0]  ns;
  } ptime_t;

  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_LOAD = 2'd1,
    OP_ARM  = 2'd2,
    OP_STOP = 2'd3
  } op_e;

  typedef struct packed {
    logic             late_ok;
    logic             pulse;
    logic             periodic;
    logic [PIN_W-1:0] pin;
  } tcfg_t;

  // a is at or after b
  function automatic logic at_or_after(ptime_t a, ptime_t b);
    return (a.sec > b.sec) || ((a.sec == b.sec) && (a.ns >= b.ns));
  endfunction

  // t + w nanoseconds, w below one second
  function automatic ptime_t advance(ptime_t t, logic [NS_W-1:0] w);
    logic [NS_W:0] sum;
    ptime_t        r;
    sum = {1'b0, t.ns} + {1'b0, w};
    if (sum >= (NS_W+1)'(NS_PER_SEC)) begin
      r.ns  = NS_W'(sum - (NS_W+1)'(NS_PER_SEC));
      r.sec = t.sec + SEC_W'(1);
    end else begin
      r.ns  = sum[NS_W-1:0];
      r.sec = t.sec;
    end
    return r;
  endfunction

endpackage

// File: rtl/ptrig_loader.sv
`timescale 1ns/1ps
module ptrig_loader
  import ptrig_pkg::*;
#(
  parameter int N_TRIG = 8,
  parameter int N_WIDE = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      load_go_i,
  input  logic [$clog2(N_TRIG)-1:0] load_id_i,
  input  logic                      word_we_i,
  input  logic [WORD_W-1:0]         word_i,
  output logic                      commit_o,
  output logic [$clog2(N_TRIG)-1:0] commit_id_o,
  output ptime_t                    start_o,
  output logic [NS_W-1:0]           width_hi_o,
  output logic [NS_W-1:0]           width_lo_o
);

  localparam int ID_W      = $clog2(N_TRIG);
  localparam int MAX_WORDS = 8;
  localparam int SHORT_LEN = 6;
  localparam int IDX_W     = $clog2(MAX_WORDS);

  logic              active_q, active_d;
  logic [ID_W-1:0]   id_q, id_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [WORD_W-1:0] shadow_q [MAX_WORDS];
  logic [WORD_W-1:0] shadow_d [MAX_WORDS];
  logic [WORD_W-1:0] merged   [MAX_WORDS];
  logic              wide;
  logic [IDX_W-1:0]  last_idx;

  assign wide     = (int'(id_q) < N_WIDE);
  assign last_idx = wide ? IDX_W'(MAX_WORDS-1) : IDX_W'(SHORT_LEN-1);
  assign commit_o = active_q && word_we_i && (idx_q == last_idx);
  assign commit_id_o = id_q;

  always_comb begin
    for (int i = 0; i < MAX_WORDS; i++) begin
      merged[i] = (word_we_i && active_q && (idx_q == IDX_W'(i))) ? word_i : shadow_q[i];
    end
  end

  assign start_o.ns  = {merged[1], merged[0]};
  assign start_o.sec = {merged[3], merged[2]};
  assign width_hi_o  = {merged[5], merged[4]};
  assign width_lo_o  = wide ? {merged[7], merged[6]} : {merged[5], merged[4]};

  always_comb begin
    active_d = active_q;
    id_d     = id_q;
    idx_d    = idx_q;
    shadow_d = shadow_q;
    if (load_go_i) begin
      active_d = 1'b1;
      id_d     = load_id_i;
      idx_d    = '0;
    end else if (active_q && word_we_i) begin
      shadow_d[idx_q] = word_i;
      if (commit_o) active_d = 1'b0;
      else          idx_d    = idx_q + IDX_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      id_q     <= '0;
      idx_q    <= '0;
    end else begin
      active_q <= active_d;
      id_q     <= id_d;
      idx_q    <= idx_d;
    end
  end

  always_ff @(posedge clk) begin
    shadow_q <= shadow_d;
  end

  // independent word count for checking the sequence length
  logic [IDX_W:0] seen_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        seen_q <= '0;
    else if (load_go_i)                seen_q <= '0;
    else if (active_q && word_we_i)    seen_q <= seen_q + (IDX_W+1)'(1);
  end

  p_commit_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
    commit_o |-> (seen_q == (wide ? (IDX_W+1)'(MAX_WORDS-1) : (IDX_W+1)'(SHORT_LEN-1))));

  p_single_commit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    commit_o && !load_go_i |=> !commit_o);

endmodule

// File: rtl/ptrig_unit.sv
`timescale 1ns/1ps
module ptrig_unit
  import ptrig_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  ptime_t           now_i,
  input  logic             cfg_we_i,
  input  tcfg_t            cfg_i,
  input  logic             load_we_i,
  input  ptime_t           start_i,
  input  logic [NS_W-1:0]  wid_hi_i,
  input  logic [NS_W-1:0]  wid_lo_i,
  input  logic             arm_i,
  input  logic             stop_i,
  output logic             level_o,
  output logic [PIN_W-1:0] pin_o
);

  tcfg_t           cfg_q, cfg_d;
  logic            armed_q, armed_d;
  logic            level_q, level_d;
  ptime_t          start_q, start_d;
  ptime_t          edge_q, edge_d;
  logic [NS_W-1:0] whi_q, whi_d, wlo_q, wlo_d;
  logic            reached;
  logic            late;

  assign reached = at_or_after(now_i, edge_q);
  assign late    = !at_or_after(start_q, now_i);
  assign level_o = level_q;
  assign pin_o   = cfg_q.pin;

  always_comb begin
    cfg_d   = cfg_we_i  ? cfg_i    : cfg_q;
    start_d = load_we_i ? start_i  : start_q;
    whi_d   = load_we_i ? wid_hi_i : whi_q;
    wlo_d   = load_we_i ? wid_lo_i : wlo_q;
    armed_d = armed_q;
    level_d = level_q;
    edge_d  = edge_q;
    if (stop_i) begin
      armed_d = 1'b0;
      level_d = 1'b0;
    end else if (arm_i) begin
      level_d = 1'b0;
      if (!late) begin
        armed_d = 1'b1;
        edge_d  = start_q;
      end else if (cfg_q.late_ok) begin
        armed_d = 1'b1;
        edge_d  = now_i;
      end else begin
        armed_d = 1'b0;
      end
    end else if (armed_q && reached) begin
      if (!level_q) begin
        level_d = 1'b1;
        if (cfg_q.periodic || cfg_q.pulse) edge_d  = advance(edge_q, whi_q);
        else                               armed_d = 1'b0;
      end else begin
        level_d = 1'b0;
        if (cfg_q.periodic) edge_d  = advance(edge_q, wlo_q);
        else                armed_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q   <= '0;
      armed_q <= 1'b0;
      level_q <= 1'b0;
    end else begin
      cfg_q   <= cfg_d;
      armed_q <= armed_d;
      level_q <= level_d;
    end
  end

  always_ff @(posedge clk) begin
    start_q <= start_d;
    edge_q  <= edge_d;
    whi_q   <= whi_d;
    wlo_q   <= wlo_d;
  end

  p_stop_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    stop_i |=> (!level_o && !armed_q));

  p_late_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    arm_i && !stop_i && late && !cfg_q.late_ok |=> !armed_q && !level_o);

  p_wait_edge_r5: assert property (@(posedge clk) disable iff (!rst_n)
    armed_q && !reached && !arm_i && !stop_i |=> $stable(level_o));

  p_late_fire_r6: assert property (@(posedge clk) disable iff (!rst_n)
    arm_i && !stop_i && late && cfg_q.late_ok |=> armed_q && !level_o);

  p_oneshot_r8: assert property (@(posedge clk) disable iff (!rst_n)
    armed_q && reached && level_q && !cfg_q.periodic && !arm_i && !stop_i |=> !armed_q && !level_o);

  p_idle_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !armed_q && !arm_i && !stop_i |=> $stable(level_o));

endmodule

// File: rtl/ptrig_pinmux.sv
`timescale 1ns/1ps
module ptrig_pinmux
  import ptrig_pkg::*;
#(
  parameter int N_TRIG = 8,
  parameter int N_PIN  = 12
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [N_TRIG-1:0]              level_i,
  input  logic [N_TRIG-1:0][PIN_W-1:0]   pin_i,
  output logic [N_PIN-1:0]               gpio_o
);

  for (genvar p = 0; p < N_PIN; p++) begin : g_pin
    logic drive;
    always_comb begin
      drive = 1'b0;
      for (int t = N_TRIG-1; t >= 0; t--) begin
        if (pin_i[t] == PIN_W'(p+1)) drive = level_i[t];
      end
    end
    assign gpio_o[p] = drive;

    p_low_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (pin_i[0] == PIN_W'(p+1)) |-> (gpio_o[p] == level_i[0]));
  end

endmodule

// File: rtl/ptrig_bank.sv
`timescale 1ns/1ps
module ptrig_bank
  import ptrig_pkg::*;
#(
  parameter int N_TRIG = 8,
  parameter int N_PIN  = 12,
  parameter int N_WIDE = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [31:0]               now_sec_i,
  input  logic [31:0]               now_ns_i,
  input  logic                      cfg_wr_i,
  input  logic [$clog2(N_TRIG)+6:0] cfg_word_i,
  input  logic [1:0]                cmd_op_i,
  input  logic [$clog2(N_TRIG)-1:0] cmd_id_i,
  input  logic                      tdr_wr_i,
  input  logic [15:0]               tdr_data_i,
  output logic [N_PIN-1:0]          gpio_o
);

  localparam int ID_W     = $clog2(N_TRIG);
  localparam int PIN_LSB  = ID_W;
  localparam int PER_BIT  = PIN_LSB + PIN_W;
  localparam int PUL_BIT  = PER_BIT + 1;
  localparam int LATE_BIT = PUL_BIT + 1;

  // asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  ptime_t          now;
  tcfg_t           cfg_f;
  logic [ID_W-1:0] cfg_id;
  op_e             op;

  assign now.sec        = now_sec_i;
  assign now.ns         = now_ns_i;
  assign cfg_id         = cfg_word_i[ID_W-1:0];
  assign cfg_f.pin      = cfg_word_i[PIN_LSB +: PIN_W];
  assign cfg_f.periodic = cfg_word_i[PER_BIT];
  assign cfg_f.pulse    = cfg_word_i[PUL_BIT];
  assign cfg_f.late_ok  = cfg_word_i[LATE_BIT];
  assign op             = op_e'(cmd_op_i);

  logic                            commit;
  logic [ID_W-1:0]                 commit_id;
  ptime_t                          ld_start;
  logic [NS_W-1:0]                 ld_whi, ld_wlo;
  logic [N_TRIG-1:0]               level;
  logic [N_TRIG-1:0][PIN_W-1:0]    pin_sel;

  ptrig_loader #(.N_TRIG(N_TRIG), .N_WIDE(N_WIDE)) u_loader (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .load_go_i   (op == OP_LOAD),
    .load_id_i   (cmd_id_i),
    .word_we_i   (tdr_wr_i),
    .word_i      (tdr_data_i),
    .commit_o    (commit),
    .commit_id_o (commit_id),
    .start_o     (ld_start),
    .width_hi_o  (ld_whi),
    .width_lo_o  (ld_wlo)
  );

  for (genvar t = 0; t < N_TRIG; t++) begin : g_unit
    logic hit_id;
    assign hit_id = (cmd_id_i == ID_W'(t));

    ptrig_unit u_unit (
      .clk       (clk),
      .rst_n     (rst_int_n),
      .now_i     (now),
      .cfg_we_i  (cfg_wr_i && (cfg_id == ID_W'(t))),
      .cfg_i     (cfg_f),
      .load_we_i (commit && (commit_id == ID_W'(t))),
      .start_i   (ld_start),
      .wid_hi_i  (ld_whi),
      .wid_lo_i  (ld_wlo),
      .arm_i     ((op == OP_ARM)  && hit_id),
      .stop_i    ((op == OP_STOP) && hit_id),
      .level_o   (level[t]),
      .pin_o     (pin_sel[t])
    );
  end

  ptrig_pinmux #(.N_TRIG(N_TRIG), .N_PIN(N_PIN)) u_mux (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .level_i (level),
    .pin_i   (pin_sel),
    .gpio_o  (gpio_o)
  );

  p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rst_int_n)
    $rose(rst_int_n) |-> (gpio_o == '0));

endmodule

// File: tb/sim_ptrig_bank.sv
`timescale 1ns/1ps
module sim_ptrig_bank;

  logic        clk;
  logic        rst_n;
  logic [31:0] now_sec, now_ns;
  logic        cfg_wr;
  logic [9:0]  cfg_word;
  logic [1:0]  cmd_op;
  logic [2:0]  cmd_id;
  logic        tdr_wr;
  logic [15:0] tdr_data;
  logic [11:0] gpio;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 0;

  ptrig_bank u0 (
    .clk(clk), .rst_n(rst_n), .now_sec_i(now_sec), .now_ns_i(now_ns),
    .cfg_wr_i(cfg_wr), .cfg_word_i(cfg_word), .cmd_op_i(cmd_op), .cmd_id_i(cmd_id),
    .tdr_wr_i(tdr_wr), .tdr_data_i(tdr_data), .gpio_o(gpio)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input string tag, input logic [11:0] got, input logic [11:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s: gpio actual=%03h expected=%03h at t=%0t", tag, got, exp, $time);
    end
  endtask

  // one clock: drive at the falling edge, release strobes after the rising edge
  task automatic cyc(input logic [31:0] s, input logic [31:0] n,
                     input logic [1:0] op, input logic [2:0] id,
                     input logic cw, input logic [9:0] cd,
                     input logic tw, input logic [15:0] td);
    @(negedge clk);
    now_sec = s; now_ns = n; cmd_op = op; cmd_id = id;
    cfg_wr = cw; cfg_word = cd; tdr_wr = tw; tdr_data = td;
    @(posedge clk);
    #1;
    cmd_op = 2'd0; cfg_wr = 1'b0; tdr_wr = 1'b0;
  endtask

  // R2 field layout
  function automatic logic [9:0] mkcfg(input int id, input int pin,
                                       input bit per, input bit pul, input bit late);
    return {late, pul, per, 4'(pin), 3'(id)};
  endfunction

  task automatic setcfg(input logic [9:0] w);
    cyc(now_sec, now_ns, 2'd0, 3'd0, 1'b1, w, 1'b0, 16'h0);
  endtask

  task automatic wr(input logic [15:0] w);
    cyc(now_sec, now_ns, 2'd0, 3'd0, 1'b0, 10'h0, 1'b1, w);
  endtask

  // R3 load order
  task automatic load(input int id, input logic [31:0] s, input logic [31:0] n,
                      input logic [31:0] w1, input logic [31:0] w2);
    cyc(now_sec, now_ns, 2'd1, 3'(id), 1'b0, 10'h0, 1'b0, 16'h0);
    wr(n[15:0]); wr(n[31:16]); wr(s[15:0]); wr(s[31:16]);
    wr(w1[15:0]); wr(w1[31:16]);
    if (id < 2) begin wr(w2[15:0]); wr(w2[31:16]); end
  endtask

  // {sec, ns, op, id, expected gpio}
  localparam int NV = 26;
  localparam logic [80:0] VEC [NV] = '{
    {32'd1, 32'd0,         2'd2, 3'd3, 12'h000},
    {32'd1, 32'd50,        2'd0, 3'd0, 12'h000},
    {32'd1, 32'd99,        2'd0, 3'd0, 12'h000},
    {32'd1, 32'd100,       2'd0, 3'd0, 12'h010},
    {32'd1, 32'd120,       2'd0, 3'd0, 12'h010},
    {32'd1, 32'd149,       2'd0, 3'd0, 12'h010},
    {32'd1, 32'd150,       2'd0, 3'd0, 12'h000},
    {32'd1, 32'd400,       2'd0, 3'd0, 12'h000},
    {32'd2, 32'd0,         2'd2, 3'd0, 12'h000},
    {32'd2, 32'd999999899, 2'd0, 3'd0, 12'h000},
    {32'd2, 32'd999999900, 2'd0, 3'd0, 12'h001},
    {32'd3, 32'd199,       2'd0, 3'd0, 12'h001},
    {32'd3, 32'd200,       2'd0, 3'd0, 12'h000},
    {32'd3, 32'd399,       2'd0, 3'd0, 12'h000},
    {32'd3, 32'd400,       2'd0, 3'd0, 12'h001},
    {32'd3, 32'd500,       2'd0, 3'd0, 12'h001},
    {32'd3, 32'd550,       2'd3, 3'd0, 12'h000},
    {32'd3, 32'd700,       2'd0, 3'd0, 12'h000},
    {32'd3, 32'd900,       2'd0, 3'd0, 12'h000},
    {32'd5, 32'd0,         2'd2, 3'd4, 12'h000},
    {32'd5, 32'd0,         2'd2, 3'd5, 12'h040},
    {32'd5, 32'd19,        2'd0, 3'd0, 12'h040},
    {32'd5, 32'd20,        2'd0, 3'd0, 12'h000},
    {32'd6, 32'd0,         2'd0, 3'd0, 12'h000},
    {32'd6, 32'd500,       2'd2, 3'd6, 12'h000},
    {32'd7, 32'd0,         2'd0, 3'd0, 12'h000}
  };

  initial begin
    rst_n = 1'b0; now_sec = '0; now_ns = '0; cfg_wr = 1'b0; cfg_word = '0;
    cmd_op = '0; cmd_id = '0; tdr_wr = 1'b0; tdr_data = '0;
    repeat (3) @(posedge clk);
    #1 chk("R1 in reset", gpio, 12'h000);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1 chk("R1 after release", gpio, 12'h000);

    // R2 configuration, R3 loads, all at time zero
    setcfg(mkcfg(3, 5, 0, 1, 0));
    setcfg(mkcfg(0, 1, 1, 1, 0));
    setcfg(mkcfg(4, 7, 0, 1, 1));
    setcfg(mkcfg(5, 8, 0, 1, 0));
    setcfg(mkcfg(6, 10, 0, 0, 0));
    setcfg(mkcfg(2, 10, 0, 0, 0));
    load(3, 32'd1, 32'd100, 32'd50, 32'd0);
    load(0, 32'd2, 32'd999999900, 32'd300, 32'd200);
    load(4, 32'd0, 32'd10, 32'd20, 32'd0);
    load(5, 32'd4, 32'd0, 32'd20, 32'd0);
    load(6, 32'd7, 32'd0, 32'd100, 32'd0);
    chk("R3 idle after loads", gpio, 12'h000);

    for (int i = 0; i < NV; i++) begin
      logic [80:0] v;
      string tag;
      v = VEC[i];
      cyc(v[80:49], v[48:17], v[16:15], v[14:12], 1'b0, 10'h0, 1'b0, 16'h0);
      if (i < 8)       tag = "R8 R5 single pulse";
      else if (i < 16) tag = "R7 R9 periodic rollover";
      else if (i < 19) tag = "R4 disarm";
      else if (i < 24) tag = "R6 R5 late start";
      else             tag = "R10 shared pin";
      chk($sformatf("%s row %0d", tag, i), gpio, v[11:0]);
    end

    // R10: unit 2 releases pin 10, unit 6 (level mode) now visible
    cyc(32'd7, 32'd10, 2'd0, 3'd0, 1'b1, mkcfg(2, 0, 0, 0, 0), 1'b0, 16'h0);
    chk("R10 pin freed", gpio, 12'h200);
    // R8: level mode stays high
    cyc(32'd9, 32'd0, 2'd0, 3'd0, 1'b0, 10'h0, 1'b0, 16'h0);
    chk("R8 level held", gpio, 12'h200);
    // R1: asynchronous reset clears immediately
    @(negedge clk) rst_n = 1'b0;
    #1 chk("R1 async clear", gpio, 12'h000);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1 chk("R1 post reset", gpio, 12'h000);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL R1 watchdog: actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

endmodule